// File: doc/BRIEF.md
# Find-First-One Conditional Jump Unit

This block evaluates a find-first-one jump. Given a 36-bit accumulator value, it counts the zero bits that sit to the left of the leftmost 1. That count is the value to be written into the second accumulator. The block also decides whether control transfers to the effective address. A zero operand yields a cleared count and no transfer. Any nonzero operand yields the count and a taken transfer.

The unit is iterative. A one-cycle `start` pulse hands it the operand. The unit then examines the operand a group of `CHUNK_W` bits at a time, beginning at the left end, and stops at the first group that contains a 1. If no group contains a 1, it stops after the last group. The count and the branch decision are registered and become valid at that point. One cycle later `done` and `writeSecond` pulse together, so the register file writes the count into the second accumulator.

The block has no write path to the first accumulator, so that register is never changed. Register-file access, effective-address generation and the PC update all belong to the surrounding pipeline.

Top module: `ffo_jump_unit`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `busy`, `done`, `writeSecond` and `branchTaken` are 0 and `leadCount` is 0.
- R2: `operand[WORD_W-1]` is the leftmost bit. For a nonzero operand, `leadCount` equals the number of 0 bits above the highest set bit.
- R3: For every nonzero operand, `branchTaken` is 1 when `done` pulses.
- R4: For a zero operand, `leadCount` is 0 and `branchTaken` is 0. `writeSecond` still pulses, so the second accumulator is cleared.
- R5: A negative operand (`operand[WORD_W-1]` = 1) gives `leadCount` = 0 with `branchTaken` = 1.
- R6: Every completion gives exactly one cycle in which `done` and `writeSecond` are both 1. `done` is never high in two consecutive cycles.
- R7: Bits are grouped in runs of CHUNK_W = 6 from the left, and c is the index of the group that holds the leftmost 1. Counted from the clock edge that samples `start`, `done` is high after edge c+2 for a nonzero operand and after edge 7 for a zero operand. `leadCount` and `branchTaken` are valid one cycle before `done`.
- R8: A `start` that arrives while `busy` is 1 is ignored. It does not change that operation's result or latency, and it does not produce an extra completion.
- R9: Between completions, `leadCount` and `branchTaken` hold their last values.
- R10: `leadCount` never exceeds WORD_W-1 (35). It reaches 35 only when the operand equals 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an evaluation; sampled only while idle |
| operand | input | WORD_W (36) | Accumulator value, sampled with `start` |
| busy | output | 1 | Evaluation in progress; `start` ignored |
| done | output | 1 | One-cycle completion pulse |
| writeSecond | output | 1 | Write strobe for the second accumulator, pulses with `done` |
| leadCount | output | CNT_W (6) | Zero count to be written into the second accumulator |
| branchTaken | output | 1 | 1 when the jump to the effective address is taken |

## Verification
The bench targets the two operands that give the same count but different branch decisions, zero and negative. A design that folds them together would either skip the jump for a negative value or take it for zero. Operands with the single set bit at either edge of a group catch a scan that loses or double-counts a group boundary; the count and the done latency both come out wrong. An operand of 1 reaches the largest count, where an undersized or mis-based counter wraps. A second `start` sent mid-scan with a different operand exposes a control path that restarts or queues work. A held-result window after completion catches registers that drift while idle.

// File: rtl/ffo_pkg.sv
`timescale 1ns/1ps
package ffo_pkg;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic load;     // capture operand, clear group base
    logic shift;    // advance to the next group
    logic capture;  // register count and branch decision
    logic pulse;    // raise the write strobe next cycle
  } ffoStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_SIGNAL = 2'd2
  } ffoState_t;

endpackage

// File: rtl/ffo_chunk_enc.sv
`timescale 1ns/1ps
// Leading-zero encoder for one group of bits; MSB of the group is leftmost.
module ffo_chunk_enc #(
  parameter int CHUNK_W = 6,
  localparam int IDX_W = (CHUNK_W > 1) ? $clog2(CHUNK_W) : 1
) (
  input  logic [CHUNK_W-1:0] chunk,
  output logic               hit,
  output logic [IDX_W-1:0]   zeros
);

  generate
    if (CHUNK_W == 1) begin : g_single
      assign hit   = chunk[0];
      assign zeros = '0;
    end else begin : g_multi
      logic found;
      always_comb begin
        zeros = '0;
        found = 1'b0;
        for (int i = 0; i < CHUNK_W; i++) begin
          if (!found && chunk[CHUNK_W-1-i]) begin
            zeros = IDX_W'(i);
            found = 1'b1;
          end
        end
      end
      assign hit = found;
    end
  endgenerate

endmodule

// File: rtl/ffo_datapath.sv
`timescale 1ns/1ps
module ffo_datapath
  import ffo_pkg::*;
#(
  parameter int WORD_W  = 36,
  parameter int CHUNK_W = 6,
  localparam int NUM_CHUNKS = (WORD_W + CHUNK_W - 1) / CHUNK_W,
  localparam int PAD_W      = NUM_CHUNKS * CHUNK_W,
  localparam int CNT_W      = (PAD_W > 1) ? $clog2(PAD_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ffoStrobes_t       ctl,
  input  logic [WORD_W-1:0] operand,
  output logic              chunkHit,
  output logic [CNT_W-1:0]  leadCount,
  output logic              branchTaken,
  output logic              writeSecond
);

  localparam int IDX_W = (CHUNK_W > 1) ? $clog2(CHUNK_W) : 1;

  logic [PAD_W-1:0]   shiftReg;
  logic [CNT_W-1:0]   baseReg;
  logic [CNT_W-1:0]   countReg;
  logic               branchReg;
  logic               writeReg;
  logic [CHUNK_W-1:0] topChunk;
  logic [IDX_W-1:0]   localZeros;

  assign topChunk = shiftReg[PAD_W-1 -: CHUNK_W];

  ffo_chunk_enc #(.CHUNK_W(CHUNK_W)) u_enc (
    .chunk (topChunk),
    .hit   (chunkHit),
    .zeros (localZeros)
  );

  // Operand window: left-aligned, padded with zeros on the right.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      baseReg  <= '0;
    end else if (ctl.load) begin
      shiftReg <= PAD_W'(operand) << (PAD_W - WORD_W);
      baseReg  <= '0;
    end else if (ctl.shift) begin
      shiftReg <= shiftReg << CHUNK_W;
      baseReg  <= baseReg + CNT_W'(CHUNK_W);
    end
  end

  // Result registers, written once per evaluation.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg  <= '0;
      branchReg <= 1'b0;
    end else if (ctl.capture) begin
      countReg  <= chunkHit ? (baseReg + CNT_W'(localZeros)) : '0;
      branchReg <= chunkHit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) writeReg <= 1'b0;
    else       writeReg <= ctl.pulse;
  end

  assign leadCount   = countReg;
  assign branchTaken = branchReg;
  assign writeSecond = writeReg;

  // R10
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    countReg <= CNT_W'(WORD_W - 1));

  // R4
  nobranch_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !branchReg |-> (countReg == '0));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> ($stable(countReg) && $stable(branchReg)));

endmodule

// File: rtl/ffo_control.sv
`timescale 1ns/1ps
module ffo_control
  import ffo_pkg::*;
#(
  parameter int NUM_CHUNKS = 6,
  localparam int IDX_W = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        chunkHit,
  output ffoStrobes_t ctl,
  output logic        busy,
  output logic        done
);

  ffoState_t        state, nextState;
  logic [IDX_W-1:0] idx;
  logic             lastChunk;
  logic             doneReg;

  assign lastChunk = (idx == IDX_W'(NUM_CHUNKS - 1));

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.load  = 1'b1;
          nextState = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (chunkHit || lastChunk) begin
          ctl.capture = 1'b1;
          nextState   = ST_SIGNAL;
        end else begin
          ctl.shift = 1'b1;
        end
      end
      ST_SIGNAL: begin
        ctl.pulse = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idx     <= '0;
      doneReg <= 1'b0;
    end else begin
      state   <= nextState;
      doneReg <= ctl.pulse;
      if (ctl.load)       idx <= '0;
      else if (ctl.shift) idx <= idx + IDX_W'(1);
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneReg;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  scan_ignores_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN && start && !chunkHit && !lastChunk) |=>
      (state == ST_SCAN && idx == $past(idx) + IDX_W'(1)));

  // R8
  idle_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/ffo_jump_unit.sv
`timescale 1ns/1ps
module ffo_jump_unit
  import ffo_pkg::*;
#(
  parameter int WORD_W  = 36,
  parameter int CHUNK_W = 6,
  localparam int NUM_CHUNKS = (WORD_W + CHUNK_W - 1) / CHUNK_W,
  localparam int PAD_W      = NUM_CHUNKS * CHUNK_W,
  localparam int CNT_W      = (PAD_W > 1) ? $clog2(PAD_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WORD_W-1:0] operand,
  output logic              busy,
  output logic              done,
  output logic              writeSecond,
  output logic [CNT_W-1:0]  leadCount,
  output logic              branchTaken
);

  ffoStrobes_t ctl;
  logic        chunkHit;

  ffo_control #(.NUM_CHUNKS(NUM_CHUNKS)) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .chunkHit (chunkHit),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done)
  );

  ffo_datapath #(.WORD_W(WORD_W), .CHUNK_W(CHUNK_W)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .operand     (operand),
    .chunkHit    (chunkHit),
    .leadCount   (leadCount),
    .branchTaken (branchTaken),
    .writeSecond (writeSecond)
  );

  // R6
  write_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done == writeSecond);

endmodule

// File: tb/ffo_jump_unit_bench.sv
`timescale 1ns/1ps
module ffo_jump_unit_bench;

  localparam int WORD_W  = 36;
  localparam int CHUNK_W = 6;
  localparam int NCHUNK  = 6;
  localparam int CNT_W   = 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [WORD_W-1:0] operand = '0;
  logic              busy, done, writeSecond, branchTaken;
  logic [CNT_W-1:0]  leadCount;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  ffo_jump_unit #(.WORD_W(WORD_W), .CHUNK_W(CHUNK_W)) u_ffo_jump_unit (
    .clk, .rstN, .start, .operand, .busy, .done,
    .writeSecond, .leadCount, .branchTaken
  );

  task automatic check(input logic ok, input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int refCount(input logic [WORD_W-1:0] v);
    for (int i = WORD_W - 1; i >= 0; i--)
      if (v[i]) return WORD_W - 1 - i;
    return 0;
  endfunction

  function automatic int refEdges(input logic [WORD_W-1:0] v);
    if (v == '0) return NCHUNK + 1;
    return refCount(v) / CHUNK_W + 2;
  endfunction

  // One evaluation; optional mid-scan start with another operand (R8).
  task automatic runCase(input logic [WORD_W-1:0] v, input string tag,
                         input logic poke);
    int expCnt, expEdges, n;
    logic expBr, got;
    expCnt   = refCount(v);
    expBr    = (v != '0);
    expEdges = refEdges(v);
    @(negedge clk);
    start = 1'b1; operand = v;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; operand = ~v;
    n = 0; got = 1'b0;
    while (!got && n < 20) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (poke) begin
        start   = (n == 1 || n == 2) ? 1'b1 : 1'b0;
        operand = 36'h8_0000_0000;
      end
      if (n == expEdges - 1) begin
        check(leadCount == CNT_W'(expCnt), "R7", "early count", leadCount, expCnt);
        check(branchTaken == expBr, "R7", "early branch", branchTaken, expBr);
        check(done == 1'b0, "R7", "done early", done, 0);
      end
      if (done) got = 1'b1;
    end
    start = 1'b0;
    check(n == expEdges, "R7", "latency edges", n, expEdges);
    check(leadCount == CNT_W'(expCnt), tag, "count", leadCount, expCnt);
    check(branchTaken == expBr, tag, "branch", branchTaken, expBr);
    check(writeSecond == 1'b1, "R4", "write strobe with done", writeSecond, 1);
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R6", "done width", done, 0);
    check(writeSecond == 1'b0, "R6", "write width", writeSecond, 0);
  endtask

  // Results must hold and no stray completion may appear (R8, R9).
  task automatic holdCheck(input int expCnt, input logic expBr);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(leadCount == CNT_W'(expCnt), "R9", "held count", leadCount, expCnt);
      check(branchTaken == expBr, "R9", "held branch", branchTaken, expBr);
      check(done == 1'b0 && busy == 1'b0, "R8", "stray completion", done, 0);
    end
  endtask

  task automatic resetCheck();
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && writeSecond == 0 && branchTaken == 0,
          "R1", "control outs in reset", {busy, done, writeSecond, branchTaken}, 0);
    check(leadCount == 0, "R1", "count in reset", leadCount, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0, "R1", "after release", {busy, done}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    resetCheck();
    runCase(36'h0_0000_0001, "R10", 1'b0);   // count 35
    runCase(36'h0_0000_0000, "R4", 1'b0);    // zero: no branch
    runCase(36'h4_0000_0000, "R2", 1'b0);    // count 1
    runCase(36'h8_0000_0000, "R5", 1'b0);    // negative: count 0, taken
    runCase(36'h0_4000_0000, "R2", 1'b0);    // count 5, last bit of group 0
    runCase(36'h0_2000_0000, "R3", 1'b0);    // count 6, first bit of group 1
    runCase(36'h7_FFFF_FFFF, "R2", 1'b0);    // count 1 with many ones
    runCase(36'h0_0000_8123, "R2", 1'b0);    // count 20, group 3
    holdCheck(20, 1'b1);
    runCase(36'h0_0000_0000, "R4", 1'b0);
    holdCheck(0, 1'b0);
    runCase(36'h0_0000_8000, "R8", 1'b1);    // start poked while busy
    holdCheck(20, 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule